// File: doc/BRIEF.md
# Local Coincidence Hit Qualifier

This block sits beside the trigger logic of one detector module in a vertical chain. Each time the local low-threshold discriminator fires, it sends a tag to the module above and to the module below. It also watches the tags that those two neighbours send back. A hit is called coincident when a neighbour tag lands within a programmable window around the local trigger. The window is symmetric, so a tag that comes before the trigger counts as well as one that comes after it.

When the window closes, the block issues one verdict for the hit. There are three possible requests:

- digitize the full waveform;
- discard the waveform data;
- keep only a coarse charge-and-time summary.

A selectable policy decides which request is made:

- **Hard:** only coincident hits are digitized.
- **Soft:** isolated hits are reduced to a summary.
- **Self:** a bright-signal trigger forces full digitization whatever the neighbours report.

The window length is given in clock periods. At a 25 ns period, the usual 1 us window is 40 periods.

Top module: `lc_hit_qualifier`

## Requirements
- R1: Every clock edge that samples `trig_lo_i` high drives both `tag_up_o` and `tag_dn_o` high for exactly the following cycle. This holds even while a window is open. Otherwise both are low.
- R2: Let W be the value of `win_len_i` at the trigger edge t. A hit is coincident when `nbr_up_tag_i` or `nbr_dn_tag_i` is sampled high at any edge from t-W to t+W, both ends included. Tags outside that range do not count.
- R3: A qualified hit gets exactly one verdict, as a single-cycle pulse that appears directly after edge t+W.
- R4: Mode code 2'b00 (hard) gives `digitize_o` for a coincident hit and no output at all for an isolated hit. Mode code 2'b11 behaves the same way.
- R5: Mode code 2'b01 (soft) gives `digitize_o` for a coincident hit. For an isolated hit it gives `discard_o` and `summary_o` together in the same cycle.
- R6: Mode code 2'b10 (self) gives `digitize_o` when `trig_hi_i` was high at the trigger edge, whatever the neighbour tags are. Otherwise it behaves as hard mode.
- R7: The mode, the bright flag and the window length are captured at the trigger edge. Changes to `mode_i` during the open window have no effect on that hit's verdict.
- R8: A trigger sampled while a window is open, up to and including its closing edge, does not start a new hit. The first trigger edge after the close does start one.
- R9: A window length of 0 counts only a neighbour tag sampled at the trigger edge itself. The verdict then appears in the cycle after that edge.
- R10: While `rst_n` is low at an edge, all outputs clear, any open window is dropped, and neighbour tag history is forgotten. A tag seen during reset never makes a later hit coincident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_lo_i | input | 1 | Local low-threshold trigger |
| trig_hi_i | input | 1 | Bright-signal (high-threshold) trigger |
| nbr_up_tag_i | input | 1 | Tag received from the upper neighbour |
| nbr_dn_tag_i | input | 1 | Tag received from the lower neighbour |
| mode_i | input | 2 | Policy: 00 hard, 01 soft, 10 self, 11 hard |
| win_len_i | input | WIN_W | Coincidence half-window in clock periods |
| tag_up_o | output | 1 | Tag pulse to the upper neighbour |
| tag_dn_o | output | 1 | Tag pulse to the lower neighbour |
| digitize_o | output | 1 | Full waveform digitize request |
| discard_o | output | 1 | Waveform discard request |
| summary_o | output | 1 | Coarse summary-only request |

## Verification
Two things can fall in the same cycle: the verdict for one hit and the tag pulse for a new local trigger. This happens when a second trigger arrives exactly at the closing edge of the first window. The bench schedules that trigger precisely W edges after the first. It expects the tags and the verdict to appear together, and it expects no second verdict later. It also places a neighbour tag on that same closing edge, and at the edges one beyond each end of the window, to confirm that both window limits are inclusive. Every cycle is judged against a behavioural model that keeps only the last tag time and a close time.

// File: rtl/lc_pkg.sv
// Package: shared types and the verdict policy of the hit qualifier.
// Assumes: mode code 2'b11 is treated as the hard policy.
package lc_pkg;

    typedef enum logic [1:0] {
        LC_HARD = 2'b00,
        LC_SOFT = 2'b01,
        LC_SELF = 2'b10,
        LC_RSVD = 2'b11
    } lc_mode_e;

    typedef struct packed {
        logic digitize;
        logic discard;
        logic summary;
    } lc_verdict_t;

    // Map the coincidence result, brightness and policy to a request set.
    function automatic lc_verdict_t lc_judge(lc_mode_e m, logic coinc, logic bright);
        lc_verdict_t v;
        v = '0;
        case (m)
            LC_SOFT: begin
                v.digitize = coinc;
                v.discard  = !coinc;
                v.summary  = !coinc;
            end
            LC_SELF: v.digitize = coinc | bright;
            default: v.digitize = coinc;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lc_tag_fanout.sv
// Module: lc_tag_fanout
// Registers one outgoing tag pulse per neighbour from the local trigger.
// Assumes: trig_i is a clean, synchronous trigger level sampled per edge.
module lc_tag_fanout #(
    parameter int NUM_NBR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_i,
    output logic [NUM_NBR-1:0] tag_o
);

    for (genvar g = 0; g < NUM_NBR; g++) begin : g_nbr
        // Echo the local trigger to neighbour g one cycle later.
        always_ff @(posedge clk) begin
            if (!rst_n) tag_o[g] <= 1'b0;
            else        tag_o[g] <= trig_i;
        end
    end

    // R1
    tag_follows_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (tag_o == {NUM_NBR{1'b1}}));

    // R1
    tag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> (tag_o == '0));

endmodule

// File: rtl/lc_tag_age.sv
// Module: lc_tag_age
// Counts edges since the last tag from one neighbour, saturating at the top.
// Assumes: a saturated value means "no tag recent enough for any window".
module lc_tag_age #(
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_i,
    output logic [AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    // Restart on a tag, otherwise age by one up to the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                age_o <= AGE_MAX;
        else if (tag_i)            age_o <= '0;
        else if (age_o != AGE_MAX) age_o <= age_o + AGE_W'(1);
    end

    // R2
    age_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_i |=> (age_o == '0));

    // R2
    age_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_o == AGE_MAX && !tag_i) |=> (age_o == AGE_MAX));

endmodule

// File: rtl/lc_window.sv
// Module: lc_window
// Holds one open coincidence window per hit and flags its closing edge.
// Assumes: recent_i already reports a tag within the look-back half-window.
module lc_window
    import lc_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             bright_i,
    input  logic             tag_now_i,
    input  logic             recent_i,
    input  lc_mode_e         mode_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             closing_o,
    output logic             coinc_o,
    output lc_mode_e         mode_o,
    output logic             bright_o
);

    logic             busy_q;
    logic [WIN_W-1:0] remain_q;
    logic             coinc_q;
    logic             bright_q;
    lc_mode_e         mode_q;
    logic             start;

    // A new hit begins only when no window is open.
    assign start = trig_i && !busy_q;

    // Closing edge: last edge of an open window, or an immediate zero window.
    always_comb begin
        closing_o = (busy_q && remain_q == WIN_W'(1)) || (start && win_len_i == '0);
        coinc_o   = busy_q ? (coinc_q | tag_now_i) : (tag_now_i | recent_i);
        mode_o    = busy_q ? mode_q : mode_i;
        bright_o  = busy_q ? bright_q : bright_i;
    end

    // Open, track and close the window; capture the hit's context at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
            coinc_q  <= 1'b0;
            bright_q <= 1'b0;
            mode_q   <= LC_HARD;
        end else if (start) begin
            busy_q   <= (win_len_i != '0);
            remain_q <= win_len_i;
            coinc_q  <= tag_now_i | recent_i;
            bright_q <= bright_i;
            mode_q   <= mode_i;
        end else if (busy_q) begin
            coinc_q  <= coinc_q | tag_now_i;
            remain_q <= remain_q - WIN_W'(1);
            if (remain_q == WIN_W'(1)) busy_q <= 1'b0;
        end
    end

    // R3
    window_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && remain_q == WIN_W'(1)) |=> !busy_q);

    // R7
    window_len_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (remain_q == $past(win_len_i)));

    // R8
    window_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (remain_q != '0));

    // R7
    window_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(mode_q));

endmodule

// File: rtl/lc_policy.sv
// Module: lc_policy
// Registers the single-cycle verdict for a hit on its closing edge.
// Assumes: closing_i is high for exactly one edge per hit.
module lc_policy
    import lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     closing_i,
    input  logic     coinc_i,
    input  lc_mode_e mode_i,
    input  logic     bright_i,
    output logic     digitize_o,
    output logic     discard_o,
    output logic     summary_o
);

    lc_verdict_t verdict;

    // Evaluate the policy for the hit being closed.
    always_comb verdict = lc_judge(mode_i, coinc_i, bright_i);

    // Pulse the requests for one cycle after the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !closing_i) begin
            digitize_o <= 1'b0;
            discard_o  <= 1'b0;
            summary_o  <= 1'b0;
        end else begin
            digitize_o <= verdict.digitize;
            discard_o  <= verdict.discard;
            summary_o  <= verdict.summary;
        end
    end

    // R5
    verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(digitize_o && discard_o));

    // R5
    discard_with_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |-> summary_o);

    // R3
    verdict_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (digitize_o || summary_o) |-> $past(closing_i));

    // R6
    self_bright_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing_i && mode_i == LC_SELF && bright_i) |=> digitize_o);

endmodule

// File: rtl/lc_hit_qualifier.sv
// Module: lc_hit_qualifier (top)
// Tags neighbours on each local trigger, qualifies the hit against neighbour
// tags in a symmetric window and issues one verdict per hit.
// Assumes: all inputs are synchronous to clk; win_len_i counts clock periods.
module lc_hit_qualifier
    import lc_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_lo_i,
    input  logic             trig_hi_i,
    input  logic             nbr_up_tag_i,
    input  logic             nbr_dn_tag_i,
    input  logic [1:0]       mode_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             tag_up_o,
    output logic             tag_dn_o,
    output logic             digitize_o,
    output logic             discard_o,
    output logic             summary_o
);

    localparam int NUM_NBR = 2;
    localparam int NBR_UP  = 0;
    localparam int NBR_DN  = 1;

    logic [NUM_NBR-1:0] tags_in;
    logic [NUM_NBR-1:0] tags_out;
    logic [NUM_NBR-1:0] recent_vec;
    logic [WIN_W-1:0]   age_arr [NUM_NBR];
    logic               closing;
    logic               coinc;
    logic               bright_eff;
    lc_mode_e           mode_eff;

    // Gather the neighbour tag inputs into one vector.
    always_comb begin
        tags_in[NBR_UP] = nbr_up_tag_i;
        tags_in[NBR_DN] = nbr_dn_tag_i;
    end

    lc_tag_fanout #(.NUM_NBR(NUM_NBR)) u_fanout (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_lo_i),
        .tag_o  (tags_out)
    );

    assign tag_up_o = tags_out[NBR_UP];
    assign tag_dn_o = tags_out[NBR_DN];

    for (genvar g = 0; g < NUM_NBR; g++) begin : g_age
        lc_tag_age #(.AGE_W(WIN_W)) u_age (
            .clk   (clk),
            .rst_n (rst_n),
            .tag_i (tags_in[g]),
            .age_o (age_arr[g])
        );
        // A tag g edges back qualifies when fewer than W edges have passed since.
        assign recent_vec[g] = (age_arr[g] < win_len_i);
    end

    lc_window #(.WIN_W(WIN_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_lo_i),
        .bright_i  (trig_hi_i),
        .tag_now_i (|tags_in),
        .recent_i  (|recent_vec),
        .mode_i    (lc_mode_e'(mode_i)),
        .win_len_i (win_len_i),
        .closing_o (closing),
        .coinc_o   (coinc),
        .mode_o    (mode_eff),
        .bright_o  (bright_eff)
    );

    lc_policy u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .closing_i  (closing),
        .coinc_i    (coinc),
        .mode_i     (mode_eff),
        .bright_i   (bright_eff),
        .digitize_o (digitize_o),
        .discard_o  (discard_o),
        .summary_o  (summary_o)
    );

    // R4
    hard_isolated_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && !coinc && mode_eff == LC_HARD) |=> !(digitize_o || discard_o || summary_o));

endmodule

// File: tb/tb_lc_hit_qualifier.sv
// Bench: behavioural per-cycle model of the qualifier, compared every cycle.
module tb_lc_hit_qualifier;

    localparam int WIN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_lo = 1'b0, trig_hi = 1'b0, up = 1'b0, dn = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [WIN_W-1:0] win = 8'd40;
    logic             tag_up, tag_dn, dig, disc, summ;

    int    compared = 0, mismatched = 0, cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    // Model state
    int   n = 0, last_tag = -100000, close_at = 0;
    bit   busy = 0, m_coinc = 0, m_bright = 0;
    logic [1:0] m_mode = 2'b00;
    logic e_tu = 0, e_td = 0, e_dig = 0, e_disc = 0, e_sum = 0;

    always #2 clk = ~clk;

    lc_hit_qualifier #(.WIN_W(WIN_W)) dut (
        .clk(clk), .rst_n(rst_n), .trig_lo_i(trig_lo), .trig_hi_i(trig_hi),
        .nbr_up_tag_i(up), .nbr_dn_tag_i(dn), .mode_i(mode), .win_len_i(win),
        .tag_up_o(tag_up), .tag_dn_o(tag_dn), .digitize_o(dig),
        .discard_o(disc), .summary_o(summ)
    );

    task automatic judge();
        e_dig = 0; e_disc = 0; e_sum = 0;
        if (m_mode == 2'b01) begin
            if (m_coinc) e_dig = 1; else begin e_disc = 1; e_sum = 1; end
        end else if (m_mode == 2'b10) e_dig = m_coinc || m_bright;
        else e_dig = m_coinc;
    endtask

    // Reference model, advanced on every clock edge from the driven inputs.
    always @(posedge clk) begin
        bit tnow;
        n = n + 1;
        e_tu = 0; e_td = 0; e_dig = 0; e_disc = 0; e_sum = 0;
        if (!rst_n) begin
            busy = 0; last_tag = -100000;
        end else begin
            tnow = up || dn;
            e_tu = trig_lo; e_td = trig_lo;
            if (busy) begin
                if (tnow) m_coinc = 1;
                if (n == close_at) begin judge(); busy = 0; end
            end else if (trig_lo) begin
                m_mode = mode; m_bright = trig_hi;
                m_coinc = tnow || ((n - last_tag) <= int'(win));
                if (win == 0) judge();
                else begin busy = 1; close_at = n + int'(win); end
            end
            if (tnow) last_tag = n;
        end
    end

    // Compare all outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if ({tag_up, tag_dn, dig, disc, summ} !== {e_tu, e_td, e_dig, e_disc, e_sum}) begin
                mismatched++;
                $display("FAIL %s cycle %0d: got tu%b td%b dig%b disc%b sum%b exp tu%b td%b dig%b disc%b sum%b",
                    (tag_up !== e_tu || tag_dn !== e_td) ? "R1" : cur_req, n,
                    tag_up, tag_dn, dig, disc, summ, e_tu, e_td, e_dig, e_disc, e_sum);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: got %0d cycles exp under 50000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic drive(input logic lo, input logic hi, input logic u, input logic d);
        trig_lo = lo; trig_hi = hi; up = u; dn = d;
        @(negedge clk);
        trig_lo = 0; trig_hi = 0; up = 0; dn = 0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        drive(0, 0, 1, 1);               // tags during reset must be forgotten
        idle(2);
        rst_n = 1;
        // R10: reset state explicit check
        compared++;
        if ({tag_up, tag_dn, dig, disc, summ} !== 5'b0) begin
            mismatched++;
            $display("FAIL R10 reset state: got %b exp 00000", {tag_up, tag_dn, dig, disc, summ});
        end
        cur_req = "R10"; mode = 2'b01;   // soft: isolated hit shows as summary
        drive(1, 0, 0, 0); idle(60);

        cur_req = "R4"; mode = 2'b00;
        drive(1, 0, 0, 0); idle(9); drive(0, 0, 1, 0); idle(100);   // coincident
        drive(1, 0, 0, 0); idle(100);                                // isolated
        mode = 2'b11;
        drive(1, 0, 0, 0); idle(4); drive(0, 0, 0, 1); idle(100);
        drive(1, 0, 0, 0); idle(100);

        cur_req = "R2"; mode = 2'b01;
        drive(0, 0, 1, 0); idle(39); drive(1, 0, 0, 0); idle(100);  // k = W before
        drive(0, 0, 0, 1); idle(40); drive(1, 0, 0, 0); idle(100);  // k = W+1 before
        drive(1, 0, 0, 0); idle(39); drive(0, 0, 1, 0); idle(100);  // at +W
        drive(1, 0, 0, 0); idle(40); drive(0, 0, 0, 1); idle(100);  // at +W+1
        drive(1, 0, 1, 0); idle(100);                                // same edge

        cur_req = "R5";
        drive(1, 0, 0, 0); idle(20); drive(0, 0, 0, 1); idle(100);
        drive(1, 0, 0, 0); idle(100);

        cur_req = "R6"; mode = 2'b10;
        drive(1, 1, 0, 0); idle(100);    // bright isolated
        drive(1, 0, 0, 0); idle(100);    // dim isolated
        drive(1, 0, 0, 0); idle(5); drive(0, 0, 1, 0); idle(100);

        cur_req = "R7"; mode = 2'b00;
        drive(1, 0, 0, 0); mode = 2'b01; idle(100);   // stays hard: nothing
        mode = 2'b10;
        drive(1, 0, 0, 0); mode = 2'b10; idle(3); drive(0, 1, 0, 0); idle(100);
        mode = 2'b01; win = 8'd10;
        drive(1, 0, 0, 0); win = 8'd60; idle(11); drive(0, 0, 1, 0); idle(100);
        win = 8'd40;

        cur_req = "R8"; mode = 2'b01;
        drive(1, 0, 0, 0); idle(9); drive(1, 0, 0, 0); idle(100);
        drive(1, 0, 0, 0); idle(39); drive(1, 0, 1, 0);   // trigger and tag at the close edge
        drive(1, 0, 0, 0); idle(100);                      // next edge starts a new hit

        cur_req = "R9"; mode = 2'b01; win = 8'd0;
        drive(1, 0, 0, 1); idle(10);
        drive(0, 0, 1, 0); drive(1, 0, 0, 0); idle(10);
        drive(1, 0, 0, 0); drive(1, 1, 0, 0); idle(10);
        mode = 2'b10; drive(1, 1, 0, 0); idle(10);

        cur_req = "R3"; mode = 2'b01; win = 8'd3;
        for (int i = 0; i < 6; i++) begin
            drive(1, 0, 0, 0); idle(i);
        end
        idle(20);
        win = 8'd255;
        drive(0, 0, 1, 0); idle(254); drive(1, 0, 0, 0); idle(300);

        cur_req = "R10"; win = 8'd40;
        drive(1, 0, 0, 0); idle(5);
        rst_n = 0; idle(2); rst_n = 1;
        idle(80);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule